// File: doc/BRIEF.md
# Registered Read-Only Memory with Selectable Output Enable

This block is a 2048-word by 8-bit read-only lookup table with a pipeline register on its read port. At every rising clock edge the word at the presented 11-bit address is loaded into an output register, so the word shows up on the outputs one clock after its address. The contents are computed when the design is elaborated and cannot be changed at run time.

The output drivers are gated by an active-low enable. A build-time parameter picks how the enable works. In sampled mode the enable is captured by a flip-flop at each rising edge, and that edge decides whether the outputs are driven. In direct mode the enable acts on the outputs at once, with no clock involved. The tri-state drivers are modelled as a data bus plus a valid flag, and the bus reads zero while it is disabled. An active-low initialise input loads a fixed start-up word into the output register immediately. A synchronous active-high reset loads the same word and turns the sampled enable off.

Top module: `regrom`

## Requirements
- R1: The word stored at address a equals the low 8 bits of ((a*37) + (a/256)*91) XOR 0x5A, where a/256 is integer division.
- R2: With the initialise input high and the reset low at a rising edge, the output register holds the word of the address present at that edge from that edge until the next one (one cycle of latency).
- R3: In sampled mode, an enable that is low at a rising edge drives the outputs (valid high) from that edge until the next edge, and enable changes between edges have no effect on the outputs.
- R4: In sampled mode, an enable that is high at a rising edge makes the outputs inactive from that edge on.
- R5: In direct mode, valid equals the inverse of the enable input at all times, with no clock edge needed.
- R6: Whenever valid is low, the data output is all zeros.
- R7: A low initialise input loads INIT_WORD (default 0xFF) into the output register without a clock edge, and the register keeps INIT_WORD at every rising edge while the input stays low.
- R8: A reset that is high at a rising edge loads INIT_WORD into the output register and turns the sampled enable off.
- R9: An address change between rising edges leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register loads on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init_n | input | 1 | Asynchronous active-low initialise |
| addr | input | 11 | Read address |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 8 | Registered data, zero when disabled |
| dout_valid | output | 1 | High when the outputs are driven |

## Verification
The inline assertions check at every clock edge that the registered word matches the function of the previous edge's address, that the sampled enable follows the enable input one edge later, that the direct enable tracks its input, that a disabled bus reads zero, and that initialise and reset load the start-up word. Only the bench scenarios can show the effects that happen between edges. These are the initialise load with no clock, the immunity of the sampled mode to enable glitches, the immediate response of the direct mode, and the stable outputs while the address changes. The bench runs a sampled-mode and a direct-mode instance side by side against one behavioural model.

// File: rtl/regrom_pkg.sv
package regrom_pkg;

  typedef enum logic {
    OE_SYNC  = 1'b0,
    OE_ASYNC = 1'b1
  } oe_mode_e;

  // Content generator evaluated at elaboration for each address.
  function automatic logic [31:0] rom_word(input int unsigned a);
    int unsigned mix;
    mix = (a * 32'd37) + ((a >> 8) * 32'd91);
    return mix ^ 32'h0000_005A;
  endfunction

endpackage

// File: rtl/regrom_array.sv
module regrom_array
  import regrom_pkg::*;
#(
  parameter int              ADDR_W    = 11,
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] INIT_WORD = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(rom_word(i));
    end
  end

  // Output register: asynchronous initialise wins over every clock edge.
  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      q <= INIT_WORD;
    end else if (rst) begin
      q <= INIT_WORD;
    end else begin
      q <= mem[addr];
    end
  end

  assert_data_path_R2: assert property (@(posedge clk) disable iff (rst)
    (init_n && $past(init_n) && !$past(rst)) |-> (q == DATA_W'(rom_word(32'($past(addr))))))
    else $error("R2: registered word does not match previous address");

  assert_init_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !init_n |-> (q == INIT_WORD))
    else $error("R7: initialise did not load start-up word");

  assert_reset_load_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(init_n) && init_n) |-> (q == INIT_WORD))
    else $error("R8: reset did not load start-up word");

endmodule

// File: rtl/regrom_gate.sv
module regrom_gate
  import regrom_pkg::*;
#(
  parameter oe_mode_e MODE = OE_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic oe_on
);

  generate
    if (MODE == OE_SYNC) begin : g_sampled
      logic en_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          en_q <= 1'b0;
        end else begin
          en_q <= !oe_n;
        end
      end

      assign oe_on = en_q;

      assert_sync_sample_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(oe_n)) |-> oe_on)
        else $error("R3: enable low at edge did not drive outputs");

      assert_sync_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(oe_n)) |-> !oe_on)
        else $error("R4: enable high at edge left outputs on");

      assert_reset_off_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !oe_on)
        else $error("R8: reset did not turn the sampled enable off");
    end else begin : g_direct
      assign oe_on = !oe_n;

      assert_async_follow_R5: assert property (@(posedge clk) disable iff (rst)
        oe_on == !oe_n)
        else $error("R5: direct enable does not follow input");
    end
  endgenerate

endmodule

// File: rtl/regrom.sv
module regrom
  import regrom_pkg::*;
#(
  parameter int                ADDR_W    = 11,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] INIT_WORD = '1,
  parameter oe_mode_e          MODE      = OE_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);

  logic [DATA_W-1:0] q;
  logic              oe_on;

  regrom_array #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .INIT_WORD(INIT_WORD)
  ) u_array (
    .clk   (clk),
    .rst   (rst),
    .init_n(init_n),
    .addr  (addr),
    .q     (q)
  );

  regrom_gate #(
    .MODE(MODE)
  ) u_gate (
    .clk  (clk),
    .rst  (rst),
    .oe_n (oe_n),
    .oe_on(oe_on)
  );

  assign dout       = oe_on ? q : '0;
  assign dout_valid = oe_on;

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !dout_valid |-> ($countones(dout) == 0))
    else $error("R6: disabled bus not zero");

endmodule

// File: tb/regrom_test.sv
module regrom_test;
  import regrom_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_n = 1'b1;
  logic [10:0] addr = '0;
  logic        oe_n = 1'b0;
  logic [7:0]  dout_s, dout_a;
  logic        val_s, val_a;

  int n_checks = 0;
  int n_fail   = 0;
  bit run      = 1'b0;
  string cur_req = "R2";

  logic [7:0] exp_q  = 8'hFF;
  logic       exp_en = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  regrom #(.MODE(OE_SYNC)) uut (
    .clk(clk), .rst(rst), .init_n(init_n), .addr(addr), .oe_n(oe_n),
    .dout(dout_s), .dout_valid(val_s)
  );

  regrom #(.MODE(OE_ASYNC)) uut_async (
    .clk(clk), .rst(rst), .init_n(init_n), .addr(addr), .oe_n(oe_n),
    .dout(dout_a), .dout_valid(val_a)
  );

  function automatic logic [7:0] ref_word(input int a);
    int v;
    v = ((a * 37) + ((a / 256) * 91)) ^ 'h5A;
    return 8'(v);
  endfunction

  // Behavioural model of the output register and sampled enable.
  always @(posedge clk) begin
    if (!init_n)   exp_q = 8'hFF;
    else if (rst)  exp_q = 8'hFF;
    else           exp_q = ref_word(int'(addr));
    exp_en = rst ? 1'b0 : !oe_n;
  end

  always @(negedge init_n) exp_q = 8'hFF;

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Per-cycle comparison of both instances against the model.
  always @(negedge clk) begin
    if (run) begin
      chk(cur_req, "sync valid", {7'd0, val_s}, {7'd0, exp_en});
      chk(cur_req, "sync data", dout_s, exp_en ? exp_q : 8'h00);
      chk(cur_req, "direct valid", {7'd0, val_a}, {7'd0, !oe_n});
      chk(cur_req, "direct data", dout_a, !oe_n ? exp_q : 8'h00);
    end
  end

  task automatic step(input logic [10:0] a, input logic oe);
    @(negedge clk); #2;
    addr = a;
    oe_n = oe;
  endtask

  initial begin
    #(100000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8", "sync valid in reset", {7'd0, val_s}, 8'd0);
    chk("R8", "sync data in reset", dout_s, 8'h00);
    chk("R8", "direct data in reset", dout_a, 8'hFF);
    #2; rst = 1'b0; run = 1'b1;

    // R1/R2: corner and stepped addresses
    cur_req = "R1";
    step(11'd0, 1'b0);   step(11'd1, 1'b0);   step(11'd255, 1'b0);
    step(11'd256, 1'b0); step(11'd2047, 1'b0); step(11'd1024, 1'b0);
    for (int i = 0; i < 40; i++) step(11'(i * 53 + 7), 1'b0);
    @(negedge clk);
    chk("R1", "word at 2047", ref_word(2047), 8'((2047 * 37 + 7 * 91) ^ 'h5A));

    // R9: address change between edges
    cur_req = "R9";
    step(11'd300, 1'b0);
    @(negedge clk); held = dout_s; #2; addr = 11'd777; #5;
    chk("R9", "sync data after mid-cycle addr", dout_s, held);
    chk("R9", "direct data after mid-cycle addr", dout_a, held);

    // R3/R5: mid-cycle enable glitch
    cur_req = "R3";
    @(negedge clk); #2; oe_n = 1'b1; #3;
    chk("R3", "sync valid ignores glitch", {7'd0, val_s}, 8'd1);
    chk("R5", "direct valid follows at once", {7'd0, val_a}, 8'd0);
    chk("R6", "direct data zero when off", dout_a, 8'h00);
    #2; oe_n = 1'b0; #1;
    chk("R5", "direct valid back on", {7'd0, val_a}, 8'd1);

    // R4/R6: enable high across an edge
    cur_req = "R4";
    step(11'd12, 1'b1);
    @(negedge clk); #1;
    chk("R4", "sync off after high edge", {7'd0, val_s}, 8'd0);
    chk("R6", "sync data zero when off", dout_s, 8'h00);
    step(11'd13, 1'b1);
    step(11'd14, 1'b0);

    // R7: asynchronous initialise, held across one edge
    cur_req = "R7";
    step(11'd500, 1'b0);
    @(negedge clk); #2; init_n = 1'b0; #3;
    chk("R7", "sync data loaded without clock", dout_s, 8'hFF);
    chk("R7", "direct data loaded without clock", dout_a, 8'hFF);
    @(negedge clk); #1;
    chk("R7", "held through edge", dout_s, 8'hFF);
    #1; init_n = 1'b1; addr = 11'd501;
    @(negedge clk); #1;
    chk("R2", "read resumes after initialise", dout_s, ref_word(501));

    // Mixed traffic
    cur_req = "R3";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #2;
      addr = 11'($urandom);
      oe_n = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) init_n = ~init_n;
    end
    @(negedge clk); #2; init_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: reset again mid-run
    cur_req = "R8";
    #2; rst = 1'b1; oe_n = 1'b0;
    @(negedge clk); #1;
    chk("R8", "reset turns sampled enable off", {7'd0, val_s}, 8'd0);
    chk("R8", "reset loads start-up word", dout_a, 8'hFF);
    #1; rst = 1'b0;
    repeat (2) @(negedge clk);

    run = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule